// File: doc/BRIEF.md
# Escape-Coded Byte Stream Splitter

This block sits on a byte-wide stream with a valid/ready handshake and separates it into two streams by means of one reserved escape value (default 0xA5). Plain bytes go to the data output unchanged. The escape value on its own is a prefix and produces no output. If a second escape value follows the prefix, a single literal escape value goes to the data output. If any other byte follows the prefix, that byte goes to a side-channel output and the data output receives nothing.

The splitter holds no byte buffer. A one-bit pending flag records that the previous accepted byte was an unpaired prefix. Every output is derived in the same cycle from the input byte and that flag. The input is stalled whenever the output that the current byte needs is not ready, so both outputs see backpressure without loss. The block does not handle framing and does not report errors. Its byte width and escape value are parameters.

Top module: `esc_stream_splitter`

## Requirements
- R1: With no prefix pending, an accepted byte that is not the escape value appears on the data output with the same value, and the side output stays idle.
- R2: With no prefix pending, an escape-valued byte is accepted at once (input ready high) and produces no output in that cycle.
- R3: A prefix followed by another escape value produces exactly one escape value on the data output and clears the pending state.
- R4: A prefix followed by a byte that is not the escape value puts that byte on the side output, and nothing goes on the data output.
- R5: In a run of escape values, bytes pair off in order. An odd run yields (n-1)/2 literals, and its last escape value pairs with the following byte as a side-channel code.
- R6: Input ready is low whenever the output that the presented byte needs has ready low. The byte is held and is delivered once that output is ready.
- R7: At most one output is valid in any cycle, and an output is valid only while the input is valid.
- R8: A synchronous active-high reset clears the pending state, so a byte after reset is treated as unprefixed. While reset is held, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | W | Incoming byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Splitter accepts the incoming byte this cycle |
| dat_data | output | W | Data-stream byte |
| dat_valid | output | 1 | Data-stream byte present |
| dat_ready | input | 1 | Data-stream consumer accepts |
| side_data | output | W | Side-channel byte |
| side_valid | output | 1 | Side-channel byte present |
| side_ready | input | 1 | Side-channel consumer accepts |

## Verification
The assertions check every cycle that the two outputs are mutually exclusive, that a stalled output holds the input off, that data-output bytes mirror the input, and that the byte after a swallowed prefix is steered to the literal or the side path. Only the bench's scenarios can show that whole sequences come out in order with nothing lost or duplicated under random backpressure. This covers the pairing of long escape runs, the mixed reference sequence and the clearing of a pending prefix by reset.

// File: rtl/esc_split_pkg.sv
package esc_split_pkg;

    typedef enum logic [1:0] {
        RT_DATA = 2'd0,
        RT_SIDE = 2'd1,
        RT_DROP = 2'd2
    } route_e;

    function automatic route_e route_pick(input logic pending, input logic is_esc);
        route_e r;
        if (!pending)
            r = is_esc ? RT_DROP : RT_DATA;
        else
            r = is_esc ? RT_DATA : RT_SIDE;
        return r;
    endfunction

endpackage

// File: rtl/esc_split_match.sv
module esc_split_match #(
    parameter int W = 8,
    parameter logic [W-1:0] ESC = 8'hA5
) (
    input  logic [W-1:0] byte_in,
    output logic         is_esc
);
    always_comb is_esc = (byte_in == ESC);
endmodule

// File: rtl/esc_split_state.sv
module esc_split_state
    import esc_split_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  route_e route,
    output logic   pending
);
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (accept)
            pending <= (route == RT_DROP);
    end
endmodule

// File: rtl/esc_split_steer.sv
module esc_split_steer
    import esc_split_pkg::*;
(
    input  route_e route,
    input  logic   in_valid,
    input  logic   dat_ready,
    input  logic   side_ready,
    output logic   dat_valid,
    output logic   side_valid,
    output logic   in_ready
);
    always_comb begin
        dat_valid  = 1'b0;
        side_valid = 1'b0;
        in_ready   = 1'b1;
        unique case (route)
            RT_DATA: begin
                dat_valid = in_valid;
                in_ready  = dat_ready;
            end
            RT_SIDE: begin
                side_valid = in_valid;
                in_ready   = side_ready;
            end
            default: in_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/esc_stream_splitter.sv
module esc_stream_splitter
    import esc_split_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] ESC = 8'hA5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] dat_data,
    output logic         dat_valid,
    input  logic         dat_ready,
    output logic [W-1:0] side_data,
    output logic         side_valid,
    input  logic         side_ready
);
    logic   is_esc;
    logic   pending;
    logic   dv_raw, sv_raw, rdy_raw;
    route_e route;

    esc_split_match #(.W(W), .ESC(ESC)) u_match (
        .byte_in (in_data),
        .is_esc  (is_esc)
    );

    always_comb route = route_pick(pending, is_esc);

    esc_split_steer u_steer (
        .route      (route),
        .in_valid   (in_valid),
        .dat_ready  (dat_ready),
        .side_ready (side_ready),
        .dat_valid  (dv_raw),
        .side_valid (sv_raw),
        .in_ready   (rdy_raw)
    );

    // Gate everything while reset is held.
    always_comb begin
        dat_valid  = dv_raw & ~rst;
        side_valid = sv_raw & ~rst;
        in_ready   = rdy_raw & ~rst;
    end

    esc_split_state u_state (
        .clk     (clk),
        .rst     (rst),
        .accept  (in_valid & in_ready),
        .route   (route),
        .pending (pending)
    );

    // A literal is the escape value itself, so both outputs carry the input byte.
    assign dat_data  = in_data;
    assign side_data = in_data;
endmodule

// File: rtl/esc_stream_splitter_chk.sv
module esc_stream_splitter_chk #(
    parameter int W = 8,
    parameter logic [W-1:0] ESC = 8'hA5
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] in_data,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] dat_data,
    input logic         dat_valid,
    input logic         dat_ready,
    input logic         side_valid,
    input logic         side_ready
);
    logic swallow;
    always_comb swallow = in_valid && in_ready && (in_data == ESC) && !dat_valid;

    // R7
    one_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(dat_valid && side_valid));

    // R7
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_valid || side_valid) |-> in_valid);

    // R6
    dat_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !dat_ready) |-> !in_ready);

    // R6
    side_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (side_valid && !side_ready) |-> !in_ready);

    // R1
    dat_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        dat_valid |-> (dat_data == in_data));

    // R3
    literal_pair_chk: assert property (@(posedge clk) disable iff (rst)
        swallow |=> (!(in_valid && in_data == ESC) || (dat_valid && !side_valid)));

    // R4
    side_pair_chk: assert property (@(posedge clk) disable iff (rst)
        swallow |=> (!(in_valid && in_data != ESC) || (side_valid && !dat_valid)));
endmodule

bind esc_stream_splitter esc_stream_splitter_chk #(.W(W), .ESC(ESC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .dat_data   (dat_data),
    .dat_valid  (dat_valid),
    .dat_ready  (dat_ready),
    .side_valid (side_valid),
    .side_ready (side_ready)
);

// File: tb/esc_stream_splitter_tb.sv
`timescale 1ns/1ps
module esc_stream_splitter_tb;
    localparam logic [7:0] ESC = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] dat_data, side_data;
    logic       dat_valid, side_valid;
    logic       dat_ready = 1'b1;
    logic       side_ready = 1'b1;

    always #4 clk = ~clk;

    esc_stream_splitter #(.W(8), .ESC(ESC)) u_dut (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .dat_data(dat_data), .dat_valid(dat_valid), .dat_ready(dat_ready),
        .side_data(side_data), .side_valid(side_valid), .side_ready(side_ready)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] dq[$];
    string      dtag[$];
    logic [7:0] sq[$];
    string      stag[$];
    bit         pend = 1'b0;
    bit         stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: model the expected routing, then present the byte until accepted.
    task automatic send(input logic [7:0] b, input string req);
        bit acc;
        bit drop;
        drop = 1'b0;
        if (!pend && b == ESC) begin pend = 1'b1; drop = 1'b1; end
        else if (!pend) begin dq.push_back(b); dtag.push_back(req); end
        else if (b == ESC) begin dq.push_back(ESC); dtag.push_back(req); pend = 1'b0; end
        else begin sq.push_back(b); stag.push_back(req); pend = 1'b0; end
        in_data  = b;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            acc = in_ready;
            if (drop) // R2: prefix swallowed at once with no output
                check(in_ready && !dat_valid && !side_valid, "R2",
                      {in_ready, dat_valid, side_valid}, 3'b100);
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    // Backpressure generator
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (stall_en) begin
            dat_ready  <= #1 lfsr[0] | lfsr[3];
            side_ready <= #1 lfsr[1] | lfsr[5];
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (dat_valid && side_valid) begin
                fails++;
                $display("FAIL R7 actual=both valid expected=at most one");
            end
            if (dat_valid && dat_ready) begin
                if (dq.size() == 0) check(1'b0, "R1 unexpected data", dat_data, 0);
                else begin
                    logic [7:0] e;
                    string t;
                    e = dq.pop_front();
                    t = dtag.pop_front();
                    check(dat_data == e, t, dat_data, e);
                end
            end
            if (side_valid && side_ready) begin
                if (sq.size() == 0) check(1'b0, "R4 unexpected side", side_data, 0);
                else begin
                    logic [7:0] e;
                    string t;
                    e = sq.pop_front();
                    t = stag.pop_front();
                    check(side_data == e, t, side_data, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] ref_in [20];
        ref_in = '{8'h01, 8'h02, 8'hA5, 8'h03, 8'h04, 8'hA5, 8'hA5, 8'h05, 8'h06, 8'hA5,
                   8'hA5, 8'hA5, 8'h07, 8'h08, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h09, 8'h0A};
        in_data = ESC;
        repeat (3) @(posedge clk);
        // R8: outputs idle while reset held
        @(negedge clk);
        in_valid = 1'b1;
        #0;
        @(negedge clk);
        check(!dat_valid && !side_valid && !in_ready, "R8 reset", {dat_valid, side_valid, in_ready}, 0);
        in_valid = 1'b0;
        @(posedge clk); #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1: plain bytes
        for (int i = 0; i < 6; i++) send(8'h10 + 8'(i), "R1");
        // R3: escape pairs
        send(ESC, "R3"); send(ESC, "R3");
        // R4: side codes
        send(ESC, "R4"); send(8'h3C, "R4");
        send(ESC, "R4"); send(8'h00, "R4");
        send(ESC, "R4"); send(8'hFF, "R4");
        // R5: odd run of five then side code
        for (int i = 0; i < 5; i++) send(ESC, "R5");
        send(8'h66, "R5");
        send(8'h77, "R5");

        // R6: hold data output off; byte must be held
        dat_ready = 1'b0;
        in_data = 8'h5A; in_valid = 1'b1;
        dq.push_back(8'h5A); dtag.push_back("R6");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!in_ready && dat_valid && dat_data == 8'h5A, "R6 data stall",
                  {in_ready, dat_valid}, 2'b01);
        end
        @(posedge clk); #1 dat_ready = 1'b1;
        @(negedge clk);
        @(posedge clk); #1 in_valid = 1'b0;
        // R6: hold side output off
        send(ESC, "R6");
        side_ready = 1'b0;
        in_data = 8'h42; in_valid = 1'b1;
        sq.push_back(8'h42); stag.push_back("R6"); pend = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!in_ready && side_valid && !dat_valid, "R6 side stall",
                  {in_ready, side_valid}, 2'b01);
        end
        @(posedge clk); #1 side_ready = 1'b1;
        @(negedge clk);
        @(posedge clk); #1 in_valid = 1'b0;

        // R5: reference sequence under random backpressure
        stall_en = 1'b1;
        for (int i = 0; i < 20; i++) send(ref_in[i], "R5 seq");
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 20; i++) send(ref_in[i] ^ 8'(r * 8'h11), "R5 mix");
        stall_en = 1'b0;
        @(posedge clk); #1 dat_ready = 1'b1; side_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        // R8: reset clears a pending prefix
        send(ESC, "R8");
        rst = 1'b1;
        pend = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        send(8'h33, "R8");
        repeat (4) @(posedge clk);

        check(dq.size() == 0, "R1 data drained", dq.size(), 0);
        check(sq.size() == 0, "R4 side drained", sq.size(), 0);
        finish_run();
    end
endmodule